// File: doc/BRIEF.md
# Radiation-Hardened Five-Step Control Sequencer

This block steps a small 8-bit processor through its instruction cycle: fetch, decode, execute, memory access and write back. A per-step completion flag from the datapath tells the sequencer when to move on. The sequencer reports where it is as a voted 3-bit code and as one strobe line per step. During the memory step it raises a memory request, but only when the current instruction is a load or a store.

Every bit of the state register is kept in three copies. A bitwise majority vote gives the effective state. That voted value drives the next-state logic, and the result is written back into all three copies on every clock. A transient flip in any one copy is therefore outvoted at once and overwritten on the next edge. A mismatch flag shows, for one cycle, that the copies disagreed. A test-only injection port can flip any single copy of any state bit, so the hardening can be exercised from the block's ports.

Top module: `ctl_seq_tmr`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the voted state is 000 (fetch), `stage_stb_o` is 00001, `mem_req_o` is 0 and `upset_o` is 0.
- R2: When `step_done` is 0 and the voted state is a legal step, that state is kept across the clock edge.
- R3: When `step_done` is 1, the state advances on the clock edge along the codes fetch 000, decode 001, execute 010, memory 011, write back 100.
- R4: From write back (100), with `step_done` at 1, the next state is fetch (000).
- R5: `stage_stb_o` is one-hot for legal states: bit 0 is fetch, bit 1 decode, bit 2 execute, bit 3 memory, bit 4 write back. It is all zero for an illegal code.
- R6: `mem_req_o` is 1 exactly when the voted state is memory (011) and `is_ldst` is 1. In every other case it is 0.
- R7: A flip of one copy of any state bit does not change the voted state, the strobes or the step sequence.
- R8: `upset_o` is 1 in the cycle after an edge at which the copies of some bit were left unequal. It returns to 0 one clock later, because all copies are rewritten from the voted value. If all three copies of a bit flip together, `upset_o` stays 0.
- R9: A voted code of 101, 110 or 111 goes to fetch (000) on the next clock, whatever the value of `step_done`.
- R10: Bit `b*3 + r` of `inj_mask` flips copy `r` of state bit `b` as that copy is loaded at the clock edge. It acts for one edge only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_done | input | 1 | The current step is complete; advance on this edge |
| is_ldst | input | 1 | The current instruction is a load or a store |
| inj_mask | input | 9 | Test flip mask, bit b*3+r targets copy r of state bit b |
| state_o | output | 3 | Majority-voted state code |
| stage_stb_o | output | 5 | One-hot step strobes |
| mem_req_o | output | 1 | Data memory request during the memory step |
| upset_o | output | 1 | The copies of some state bit disagree |

## Verification
Inputs are applied at a falling edge and take effect at the next rising edge. The voted state, strobes and upset flag are all due exactly one rising edge after the inputs that caused them, because only the copy registers stand between input and output. The memory request also follows the `is_ldst` level still held after that edge. Each drive step queues one expected record. The monitor pops that record 1 ns after the rising edge, so every check samples the settled outputs of that single edge. Injected single flips, double flips that force an illegal code, and triple flips are each followed by a clean step, to confirm the scrub one clock later.

// File: rtl/ctl_seq_pkg.sv
`timescale 1ns/1ps
package ctl_seq_pkg;
   localparam int SEQ_STATE_W    = 3;
   localparam int SEQ_NUM_STEPS  = 5;
   localparam int SEQ_COPIES     = 3;
   localparam int SEQ_MEM_IDX    = 3;

   typedef enum logic [SEQ_STATE_W-1:0] {
      STEP_FETCH  = 3'd0,
      STEP_DECODE = 3'd1,
      STEP_EXEC   = 3'd2,
      STEP_MEM    = 3'd3,
      STEP_WB     = 3'd4
   } seq_step_e;
endpackage

// File: rtl/tmr_bit_cell.sv
`timescale 1ns/1ps
module tmr_bit_cell #(
   parameter int   COPIES    = 3,
   parameter int   VOTE_IMPL = 0,
   parameter logic RST_VAL   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_i,
   input  logic [COPIES-1:0] inj_i,
   output logic              q_o,
   output logic              mismatch_o
);
   localparam int MAJ = COPIES / 2 + 1;

   if (COPIES != 3) begin : g_copies_chk
      $error("tmr_bit_cell supports exactly three copies");
   end
   if (VOTE_IMPL < 0 || VOTE_IMPL > 1) begin : g_impl_chk
      $error("tmr_bit_cell VOTE_IMPL must be 0 or 1");
   end

   logic [COPIES-1:0] copy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         copy_q <= {COPIES{RST_VAL}};
      end else begin
         copy_q <= {COPIES{d_i}} ^ inj_i;
      end
   end

   if (VOTE_IMPL == 0) begin : g_vote_gates
      assign q_o = (copy_q[0] & copy_q[1]) | (copy_q[1] & copy_q[2]) |
                   (copy_q[0] & copy_q[2]);
   end else begin : g_vote_count
      always_comb begin
         q_o = ($countones(copy_q) >= MAJ);
      end
   end

   assign mismatch_o = !((&copy_q) || !(|copy_q));

   // R8
   scrub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_i == '0) |=> !mismatch_o);
endmodule

// File: rtl/seq_next_state.sv
`timescale 1ns/1ps
module seq_next_state #(
   parameter int STATE_W   = 3,
   parameter int NUM_STEPS = 5
) (
   input  logic [STATE_W-1:0] cur_i,
   input  logic               step_done,
   output logic [STATE_W-1:0] nxt_o
);
   localparam logic [STATE_W-1:0] LAST  = STATE_W'(NUM_STEPS - 1);
   localparam logic [STATE_W-1:0] FIRST = '0;

   if (NUM_STEPS > (1 << STATE_W) || NUM_STEPS < 2) begin : g_steps_chk
      $error("seq_next_state: NUM_STEPS does not fit STATE_W");
   end

   always_comb begin
      if (cur_i > LAST) begin
         nxt_o = FIRST;
      end else if (!step_done) begin
         nxt_o = cur_i;
      end else if (cur_i == LAST) begin
         nxt_o = FIRST;
      end else begin
         nxt_o = cur_i + 1'b1;
      end
   end
endmodule

// File: rtl/seq_strobe_dec.sv
`timescale 1ns/1ps
module seq_strobe_dec #(
   parameter int STATE_W   = 3,
   parameter int NUM_STEPS = 5,
   parameter int MEM_IDX   = 3
) (
   input  logic [STATE_W-1:0]   state_i,
   input  logic                 is_ldst,
   output logic [NUM_STEPS-1:0] stb_o,
   output logic                 mem_req_o
);
   if (MEM_IDX >= NUM_STEPS) begin : g_mem_chk
      $error("seq_strobe_dec: MEM_IDX outside the step range");
   end

   for (genvar i = 0; i < NUM_STEPS; i++) begin : g_stb
      assign stb_o[i] = (state_i == STATE_W'(i));
   end

   assign mem_req_o = stb_o[MEM_IDX] & is_ldst;
endmodule

// File: rtl/ctl_seq_tmr.sv
`timescale 1ns/1ps
module ctl_seq_tmr
   import ctl_seq_pkg::*;
#(
   parameter int STATE_W   = SEQ_STATE_W,
   parameter int NUM_STEPS = SEQ_NUM_STEPS,
   parameter int COPIES    = SEQ_COPIES,
   parameter int MEM_IDX   = SEQ_MEM_IDX,
   parameter int VOTE_IMPL = 0,
   localparam int INJ_W    = STATE_W * COPIES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step_done,
   input  logic                 is_ldst,
   input  logic [INJ_W-1:0]     inj_mask,
   output logic [STATE_W-1:0]   state_o,
   output logic [NUM_STEPS-1:0] stage_stb_o,
   output logic                 mem_req_o,
   output logic                 upset_o
);
   localparam logic [STATE_W-1:0] LAST_CODE = STATE_W'(NUM_STEPS - 1);
   localparam logic [STATE_W-1:0] MEM_CODE  = STATE_W'(MEM_IDX);

   if (COPIES != 3) begin : g_copies_chk
      $error("ctl_seq_tmr: three copies per bit are required");
   end

   logic [STATE_W-1:0] voted;
   logic [STATE_W-1:0] nxt;
   logic [STATE_W-1:0] bit_mm;

   seq_next_state #(
      .STATE_W  (STATE_W),
      .NUM_STEPS(NUM_STEPS)
   ) i_next (
      .cur_i    (voted),
      .step_done(step_done),
      .nxt_o    (nxt)
   );

   for (genvar b = 0; b < STATE_W; b++) begin : g_bit
      tmr_bit_cell #(
         .COPIES   (COPIES),
         .VOTE_IMPL(VOTE_IMPL),
         .RST_VAL  (1'b0)
      ) i_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .d_i       (nxt[b]),
         .inj_i     (inj_mask[b*COPIES +: COPIES]),
         .q_o       (voted[b]),
         .mismatch_o(bit_mm[b])
      );
   end

   seq_strobe_dec #(
      .STATE_W  (STATE_W),
      .NUM_STEPS(NUM_STEPS),
      .MEM_IDX  (MEM_IDX)
   ) i_dec (
      .state_i  (voted),
      .is_ldst  (is_ldst),
      .stb_o    (stage_stb_o),
      .mem_req_o(mem_req_o)
   );

   assign state_o = voted;
   assign upset_o = |bit_mm;

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (state_o == '0));

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_done && inj_mask == '0 && state_o <= LAST_CODE) |=> $stable(state_o));

   // R4
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_done && inj_mask == '0 && state_o == LAST_CODE) |=> (state_o == '0));

   // R5
   onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stage_stb_o) && ((state_o <= LAST_CODE) == (stage_stb_o != '0)));

   // R6
   memreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (state_o == MEM_CODE && is_ldst));

   // R9
   illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o > LAST_CODE && inj_mask == '0) |=> (state_o == '0));
endmodule

// File: tb/test_ctl_seq_tmr.sv
`timescale 1ns/1ps
module test_ctl_seq_tmr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_done = 1'b0;
   logic       is_ldst = 1'b0;
   logic [8:0] inj_mask = '0;
   logic [2:0] state_o;
   logic [4:0] stage_stb_o;
   logic       mem_req_o;
   logic       upset_o;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   ctl_seq_tmr i_ctl_seq_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_done  (step_done),
      .is_ldst    (is_ldst),
      .inj_mask   (inj_mask),
      .state_o    (state_o),
      .stage_stb_o(stage_stb_o),
      .mem_req_o  (mem_req_o),
      .upset_o    (upset_o)
   );

   typedef struct {
      logic [2:0] st;
      logic [4:0] stb;
      logic       mreq;
      logic       mm;
      string      tag;
   } exp_t;

   exp_t       sb_q[$];
   exp_t       cur;
   logic [2:0] m_st;

   function automatic logic [2:0] model_next(logic [2:0] s, logic d);
      if (s > 3'd4) return 3'd0;
      if (!d) return s;
      if (s == 3'd4) return 3'd0;
      return s + 3'd1;
   endfunction

   task automatic check(input string tag, input logic [2:0] a_st, input logic [4:0] a_stb,
                        input logic a_mr, input logic a_mm, input logic [2:0] e_st,
                        input logic [4:0] e_stb, input logic e_mr, input logic e_mm);
      n_checks++;
      if (a_st !== e_st || a_stb !== e_stb || a_mr !== e_mr || a_mm !== e_mm) begin
         n_errors++;
         $display("FAIL %s: state=%b stb=%b mreq=%b upset=%b expected state=%b stb=%b mreq=%b upset=%b",
                  tag, a_st, a_stb, a_mr, a_mm, e_st, e_stb, e_mr, e_mm);
      end
   endtask

   // driver: apply inputs at the falling edge and queue what the next rising edge must show
   task automatic drive(input logic done, input logic ldst, input logic [8:0] inj, input string tag);
      exp_t e;
      logic [2:0] nx;
      logic       mm;
      @(negedge clk);
      step_done = done;
      is_ldst   = ldst;
      inj_mask  = inj;
      nx = model_next(m_st, done);
      mm = 1'b0;
      for (int b = 0; b < 3; b++) begin
         int cnt;
         cnt = int'(inj[b*3]) + int'(inj[b*3+1]) + int'(inj[b*3+2]);
         if (cnt >= 2) nx[b] = ~nx[b];
         if (cnt == 1 || cnt == 2) mm = 1'b1;
      end
      m_st   = nx;
      e.st   = nx;
      e.stb  = (nx <= 3'd4) ? (5'b00001 << nx) : 5'b00000;
      e.mreq = (nx == 3'd3) && ldst;
      e.mm   = mm;
      e.tag  = tag;
      sb_q.push_back(e);
   endtask

   // monitor: compare one queued record shortly after each rising edge
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         cur = sb_q.pop_front();
         check(cur.tag, state_o, stage_stb_o, mem_req_o, upset_o,
               cur.st, cur.stb, cur.mreq, cur.mm);
      end
   end

   task automatic go_to(input logic [2:0] target);
      while (m_st != target) drive(1'b1, 1'b0, 9'd0, "R3");
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      m_st = 3'd0;
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1", state_o, stage_stb_o, mem_req_o, upset_o, 3'd0, 5'b00001, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      // R2 hold at fetch
      drive(1'b0, 1'b0, 9'd0, "R1");
      drive(1'b0, 1'b1, 9'd0, "R2");
      // R3 walk the sequence, R6 load/store in memory step
      drive(1'b1, 1'b0, 9'd0, "R3");
      drive(1'b0, 1'b0, 9'd0, "R2");
      drive(1'b1, 1'b0, 9'd0, "R3");
      drive(1'b1, 1'b1, 9'd0, "R6");
      drive(1'b0, 1'b0, 9'd0, "R6");
      drive(1'b0, 1'b1, 9'd0, "R6");
      drive(1'b1, 1'b1, 9'd0, "R5");
      drive(1'b0, 1'b1, 9'd0, "R6");
      // R4 wrap
      drive(1'b1, 1'b0, 9'd0, "R4");
      // R7/R10 single flips on each copy of each bit, each followed by a clean step (R8)
      for (int k = 0; k < 9; k++) begin
         drive(k % 2 == 0, 1'b0, 9'd1 << k, "R10");
         drive(1'b1, 1'b0, 9'd0, "R8");
      end
      // R7 flip while holding in the memory step with a load
      go_to(3'd3);
      drive(1'b0, 1'b1, 9'b000_000_100, "R7");
      drive(1'b0, 1'b1, 9'd0, "R8");
      // R9 forced illegal codes through double flips
      go_to(3'd4);
      drive(1'b0, 1'b0, 9'b000_000_011, "R9");
      drive(1'b0, 1'b0, 9'd0, "R9");
      go_to(3'd4);
      drive(1'b0, 1'b0, 9'b000_110_000, "R9");
      drive(1'b1, 1'b0, 9'd0, "R9");
      go_to(3'd3);
      drive(1'b0, 1'b0, 9'b101_000_000, "R9");
      drive(1'b0, 1'b0, 9'd0, "R9");
      // R8 all three copies of one bit flip: no disagreement
      drive(1'b0, 1'b0, 9'b000_111_000, "R8");
      drive(1'b0, 1'b0, 9'd0, "R8");
      // mixed pattern of steps and holds
      for (int i = 0; i < 30; i++) begin
         drive(i % 3 != 0, i % 2 == 1, 9'd0, "R3");
      end
      @(negedge clk);
      inj_mask = '0;
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule